// File: doc/BRIEF.md
# Stepped Power-Down Clock Post-Divider

This block turns a fast synthesizer clock into a slower output clock with a 50 % duty cycle. The block's clock `clk2x` runs at twice the VCO rate, so a division ratio R shows up as R `clk2x` cycles high followed by R cycles low. A 2-bit select picks a base ratio. A power-down request raises the ratio by a further factor of 16.

The change into or out of power-down does not happen at once. It is taken in four doubling (or halving) steps. Each step is paced by a single-cycle strobe that marks reference-clock events, and the request is looked at only on those strobes. Every ratio change, whether from the select or from a step, is applied only at the start of a new output period, after a complete low phase, so no phase is ever cut short. The output enable is resampled when a high phase ends. This means the output can stop or resume only at the start of a full low phase. A disabled output rests with the true output low and the complement high.

Top module: `pd_clk_postdiv`

## Requirements
- R1: With the step level at zero, select code 00 gives a ratio of 2, 01 gives 4, 10 gives 8 and 11 gives 1. A ratio R means R `clk2x` cycles high and then R cycles low on `clk_out`.
- R2: With power-down fully applied, the same codes give ratios of 32, 64, 128 and 16.
- R3: Each `ref_stb` cycle on which `pwr_dn` is 1 doubles the extra factor, one step per strobe, through 1, 2, 4, 8, 16. Strobes after it reaches 16 leave it at 16.
- R4: Each `ref_stb` cycle on which `pwr_dn` is 0 halves the extra factor, through 16, 8, 4, 2, 1. Strobes after it reaches 1 leave it at 1.
- R5: `pwr_dn` has no effect on cycles without `ref_stb`.
- R6: A new ratio takes effect only when a new high phase begins after a complete low phase. No high or low phase is ever shorter than the ratio in force when it began.
- R7: `out_en` is sampled on the cycle a high phase ends. While the sampled value is 0, `clk_out` is 0 and `clk_out_n` is 1.
- R8: During reset, `clk_out` is 0, `clk_out_n` is 1 and the extra factor is 1. The sampled enable starts out at 0, so the first output high phase after reset is suppressed.
- R9: `clk_out_n` is always the complement of `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the VCO rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | 1 | One-cycle strobe for each reference-clock event; paces the power-down steps |
| div_sel | input | 2 | Base ratio select (00:2, 01:4, 10:8, 11:1) |
| pwr_dn | input | 1 | Power-down request |
| out_en | input | 1 | Output enable, active high |
| clk_out | output | 1 | Divided clock, true polarity |
| clk_out_n | output | 1 | Divided clock, complement |

## Verification
Both outputs are registered and change on the same `clk2x` edge as the internal phase. The bench therefore samples them on the falling edge that follows each rising edge. A select change or a step takes effect at the start of the next high phase, never mid-period. For that reason each directed ratio check discards the first full period after a stimulus and measures the second. A change of `out_en` is only due at the next end of a high phase, so the disable check waits longer than the longest ratio in force before it inspects the outputs. A cycle-by-cycle model built from the requirements runs alongside the design under random stimulus. It predicts each output one edge after the inputs it depends on.

// File: rtl/pd_postdiv_pkg.sv
package pd_postdiv_pkg;
   // largest base log2 ratio among the select codes
   localparam int unsigned BASE_LOG_MAX = 3;

   // log2 of the base ratio for a select code: 00->1, 01->2, 10->3, 11->0
   function automatic logic [1:0] base_log(input logic [1:0] sel);
      logic [1:0] r;
      case (sel)
         2'b00:   r = 2'd1;
         2'b01:   r = 2'd2;
         2'b10:   r = 2'd3;
         default: r = 2'd0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/pd_step_ctrl.sv
module pd_step_ctrl #(
   parameter int unsigned PD_STEPS = 4,
   parameter int unsigned STEP_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_stb,
   input  logic              pwr_dn,
   output logic [STEP_W-1:0] step
);
   localparam logic [STEP_W-1:0] TOP = STEP_W'(PD_STEPS);

   logic [STEP_W-1:0] step_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (ref_stb) begin
         if (pwr_dn && step_q != TOP)
            step_q <= step_q + 1'b1;
         else if (!pwr_dn && step_q != '0)
            step_q <= step_q - 1'b1;
      end
   end

   assign step = step_q;

   // R3 R4
   step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_q <= TOP);

   // R5
   step_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_stb |=> $stable(step_q));
endmodule

// File: rtl/pd_phase_gen.sv
module pd_phase_gen
   import pd_postdiv_pkg::*;
#(
   parameter int unsigned LOG_W  = 3,
   parameter int unsigned CNT_W  = 7,
   parameter int unsigned STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        div_sel,
   input  logic [STEP_W-1:0] step,
   output logic              hi_nxt,
   output logic              fall_nxt
);
   logic             phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [LOG_W-1:0] log_q;
   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] last;
   logic             at_end;

   always_comb begin
      span     = (CNT_W+1)'(1) << log_q;
      last     = CNT_W'(span - 1'b1);
      at_end   = (cnt_q == last);
      hi_nxt   = at_end ? ~phase_q : phase_q;
      fall_nxt = at_end & phase_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         cnt_q   <= '0;
         log_q   <= '0;
      end else if (at_end) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
         if (!phase_q)
            log_q <= LOG_W'(base_log(div_sel)) + LOG_W'(step);
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6
   ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(log_q) |-> $rose(phase_q));

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= last);
endmodule

// File: rtl/pd_oe_sync.sv
module pd_oe_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic hi_nxt,
   input  logic fall_nxt,
   input  logic out_en,
   output logic clk_out,
   output logic clk_out_n
);
   logic en_q;
   logic out_q;
   logic en_nxt;

   assign en_nxt = fall_nxt ? out_en : en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         out_q <= 1'b0;
      end else begin
         en_q  <= en_nxt;
         out_q <= hi_nxt & en_nxt;
      end
   end

   assign clk_out   = out_q;
   assign clk_out_n = ~out_q;

   // R7
   en_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(en_q) |-> !out_q);

   // R7
   rise_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q) |-> en_q);
endmodule

// File: rtl/pd_clk_postdiv.sv
module pd_clk_postdiv #(
   parameter int unsigned PD_STEPS = 4
) (
   input  logic       clk2x,
   input  logic       rst_n,
   input  logic       ref_stb,
   input  logic [1:0] div_sel,
   input  logic       pwr_dn,
   input  logic       out_en,
   output logic       clk_out,
   output logic       clk_out_n
);
   localparam int unsigned CNT_W  = pd_postdiv_pkg::BASE_LOG_MAX + PD_STEPS;
   localparam int unsigned LOG_W  = $clog2(CNT_W + 1);
   localparam int unsigned STEP_W = $clog2(PD_STEPS + 1);

   generate
      if (PD_STEPS < 1 || PD_STEPS > 8) begin : g_bad_steps
         $error("PD_STEPS must lie in 1..8");
      end
   endgenerate

   logic [STEP_W-1:0] step;
   logic              hi_nxt;
   logic              fall_nxt;

   pd_step_ctrl #(.PD_STEPS(PD_STEPS), .STEP_W(STEP_W)) u_step (
      .clk     (clk2x),
      .rst_n   (rst_n),
      .ref_stb (ref_stb),
      .pwr_dn  (pwr_dn),
      .step    (step)
   );

   pd_phase_gen #(.LOG_W(LOG_W), .CNT_W(CNT_W), .STEP_W(STEP_W)) u_phase (
      .clk      (clk2x),
      .rst_n    (rst_n),
      .div_sel  (div_sel),
      .step     (step),
      .hi_nxt   (hi_nxt),
      .fall_nxt (fall_nxt)
   );

   pd_oe_sync u_oe (
      .clk       (clk2x),
      .rst_n     (rst_n),
      .hi_nxt    (hi_nxt),
      .fall_nxt  (fall_nxt),
      .out_en    (out_en),
      .clk_out   (clk_out),
      .clk_out_n (clk_out_n)
   );

   // R9
   complement_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
      clk_out_n != clk_out);
endmodule

// File: tb/pd_clk_postdiv_test.sv
module pd_clk_postdiv_test;
   localparam time PERIOD = 10ns;

   logic       clk2x = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_stb = 1'b0;
   logic [1:0] div_sel = 2'b00;
   logic       pwr_dn = 1'b0;
   logic       out_en = 1'b1;
   logic       clk_out, clk_out_n;

   int checks = 0;
   int errors = 0;

   always #(PERIOD/2) clk2x = ~clk2x;

   pd_clk_postdiv uut (
      .clk2x(clk2x), .rst_n(rst_n), .ref_stb(ref_stb), .div_sel(div_sel),
      .pwr_dn(pwr_dn), .out_en(out_en), .clk_out(clk_out), .clk_out_n(clk_out_n)
   );

   // ratio expected from the requirements (R1, R2)
   function automatic int exp_ratio(input logic [1:0] sel, input int extra);
      int b;
      case (sel)
         2'b00: b = 2;
         2'b01: b = 4;
         2'b10: b = 8;
         default: b = 1;
      endcase
      return b * extra;
   endfunction

   // cycle model: R1..R9 behaviour one rising edge at a time
   int m_extra = 1;
   int m_ratio = 1;
   int m_cnt = 0;
   bit m_hi = 0;
   bit m_en = 0;
   bit m_out = 0;

   always @(posedge clk2x) begin
      if (!rst_n) begin
         m_extra = 1; m_ratio = 1; m_cnt = 0; m_hi = 0; m_en = 0; m_out = 0;
      end else begin
         if (m_cnt == m_ratio - 1) begin
            m_cnt = 0;
            if (m_hi) begin
               m_hi = 0;
               m_en = out_en;
            end else begin
               m_hi = 1;
               m_ratio = exp_ratio(div_sel, m_extra);
            end
         end else begin
            m_cnt++;
         end
         m_out = m_hi & m_en;
         if (ref_stb) begin
            if (pwr_dn && m_extra < 16) m_extra = m_extra * 2;
            else if (!pwr_dn && m_extra > 1) m_extra = m_extra / 2;
         end
      end
   end

   // R6 R9: per-cycle comparison against the model
   always @(negedge clk2x) begin
      if (rst_n) begin
         checks++;
         if (clk_out !== m_out || clk_out_n !== ~m_out) begin
            errors++;
            $display("FAIL R6/R9 cycle model: clk_out=%b clk_out_n=%b expected %b/%b",
                     clk_out, clk_out_n, m_out, ~m_out);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic measure(output int hl, output int ll);
      while (clk_out) @(negedge clk2x);
      while (!clk_out) @(negedge clk2x);
      hl = 0;
      while (clk_out) begin hl++; @(negedge clk2x); end
      ll = 0;
      while (!clk_out) begin ll++; @(negedge clk2x); end
   endtask

   // second full period after a change
   task automatic settled(input string req, input int exp);
      int hl, ll;
      measure(hl, ll);
      measure(hl, ll);
      check(req, hl, exp);
      check(req, ll, exp);
   endtask

   task automatic strobe();
      @(negedge clk2x) ref_stb = 1'b1;
      @(negedge clk2x) ref_stb = 1'b0;
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk2x);
      // R8: reset state
      check("R8 clk_out in reset", clk_out, 0);
      check("R8 clk_out_n in reset", clk_out_n, 1);
      rst_n = 1'b1;
      @(negedge clk2x);
      check("R8 clk_out after reset", clk_out, 0);

      // R1: base ratios
      for (int s = 0; s < 4; s++) begin
         div_sel = 2'(s);
         settled("R1 base ratio", exp_ratio(2'(s), 1));
      end

      // R5: request without strobes does nothing
      div_sel = 2'b00;
      pwr_dn = 1'b1;
      settled("R5 no strobe", 2);

      // R2: full power-down ratios
      repeat (4) strobe();
      for (int s = 0; s < 4; s++) begin
         div_sel = 2'(s);
         settled("R2 power-down ratio", exp_ratio(2'(s), 16));
      end

      // R3: stepwise entry with select 11
      pwr_dn = 1'b0;
      repeat (4) strobe();
      div_sel = 2'b11;
      settled("R3 start level", 1);
      pwr_dn = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         strobe();
         settled("R3 entry step", (k < 4) ? (1 << k) : 16);
      end

      // R4: stepwise exit
      pwr_dn = 1'b0;
      for (int k = 1; k <= 5; k++) begin
         strobe();
         settled("R4 exit step", (k < 4) ? (16 >> k) : 1);
      end

      // R7: disable holds true low, complement high
      div_sel = 2'b10;
      settled("R7 pre-disable ratio", 8);
      out_en = 1'b0;
      repeat (40) @(negedge clk2x);
      for (int i = 0; i < 20; i++) begin
         check("R7 disabled clk_out", clk_out, 0);
         check("R7 disabled clk_out_n", clk_out_n, 1);
         @(negedge clk2x);
      end
      out_en = 1'b1;
      settled("R7 re-enabled ratio", 8);

      // random stimulus against the cycle model (R3 R4 R5 R6 R7 R9)
      void'($urandom(32'd1234));
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk2x);
         ref_stb = ($urandom % 20) == 0;
         if (($urandom % 300) == 0) div_sel = 2'($urandom);
         if (($urandom % 700) == 0) pwr_dn = ~pwr_dn;
         if (($urandom % 400) == 0) out_en = ~out_en;
      end
      ref_stb = 1'b0;
      repeat (4) @(negedge clk2x);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule